// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 operands given as raw bit patterns and produces a two-bit condition code, written into a copy of the floating-point status register. A precision-select input chooses between 32-bit operands, taken from the low word of each operand bus, and 64-bit operands. The decoding of NaN, zero, sign and magnitude is done on the bits directly; no floating-point arithmetic is involved.

A compare is started by a one-cycle strobe. The unit then returns the whole status register with the condition field replaced. When the compare is unordered, it also either requests a floating-point exception trap or sets a sticky accrued-invalid flag, depending on the invalid-trap enable bit of the incoming status word. All results come from registers. They are due on the clock edge that samples the strobe, and they hold until the next strobe.

Top module: `fpcmp_unit`

## Requirements
- R1: Condition codes are: A less than B gives 2'b01, A greater than B gives 2'b10, equal gives 2'b00. The code appears in status bits [11:10] (bit 10 is the low code bit) and on `cc_o`, with the same encoding for both precisions.
- R2: Ordering follows sign. A negative non-zero operand is below any positive operand, and two negative operands are ordered by reversed magnitude (-1.0 is greater than -2.0).
- R3: Positive zero and negative zero compare as equal (code 2'b00).
- R4: An operand is NaN when its exponent field is all ones and its fraction is non-zero. If either operand is NaN, the code is 2'b11. An infinity (all-ones exponent, zero fraction) is ordered normally.
- R5: On an unordered result with status bit 23 (invalid-trap enable) set, `trap_o` is 1 in the same cycle as `done_o`, and status bit 5 is copied unchanged.
- R6: On an unordered result with status bit 23 clear, status bit 5 (accrued invalid, also on `acc_inv_o`) is set and `trap_o` stays 0. Bit 5 is sticky: an ordered compare copies it from the input unchanged.
- R7: With `dbl_i`=1 the operands are the full 64-bit words. With `dbl_i`=0 only bits [31:0] of each operand are used, and bits [63:32] have no effect on the result.
- R8: Results are registered on the rising edge that samples `start_i`=1. `done_o` is 1 for exactly that following cycle. All status bits other than [11:10] and 5 are copied from `sr_i`.
- R9: Without a start, `sr_o`, `cc_o` and `acc_inv_o` hold their values, and `done_o` and `trap_o` are 0.
- R10: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle compare strobe |
| dbl_i | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands in bits [31:0] |
| opa_i | input | 64 | Operand A bit pattern |
| opb_i | input | 64 | Operand B bit pattern |
| sr_i | input | 32 | Current status register |
| sr_o | output | 32 | Updated status register |
| cc_o | output | 2 | Condition code (status bits [11:10]) |
| acc_inv_o | output | 1 | Accrued-invalid flag (status bit 5) |
| trap_o | output | 1 | Exception trap request pulse |
| done_o | output | 1 | Compare-complete pulse |

## Verification
Every result of a compare lands one clock edge after the strobe: the condition code, the updated status word, the accrued flag, the trap pulse and the done pulse. The bench raises the strobe on a falling edge, lowers it on the next falling edge, and samples all outputs there, half a period after the capturing rising edge. The hold behaviour is checked one cycle later again, after the operands and status input have been changed with no strobe. Because the reset release is synchronised internally, the bench waits several cycles after reset before the first strobe.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  localparam int OP_W    = 64;
  localparam int SP_W    = 32;
  localparam int SP_EXP  = 8;
  localparam int SP_FRAC = 23;
  localparam int DP_EXP  = 11;
  localparam int DP_FRAC = 52;
  localparam int MAG_W   = OP_W - 1;

  typedef enum logic [1:0] {
    CC_EQ = 2'b00,
    CC_LT = 2'b01,
    CC_GT = 2'b10,
    CC_UN = 2'b11
  } cc_t;

  typedef struct packed {
    logic             neg;
    logic             nan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } fp_info_t;

endpackage

// File: rtl/fpcmp_rst_sync.sv
module fpcmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic            dbl_i,
  output fp_info_t        info_o
);

  localparam int SP_SIGN = SP_W - 1;
  localparam int DP_SIGN = OP_W - 1;

  logic [SP_EXP-1:0]  sp_exp;
  logic [SP_FRAC-1:0] sp_frac;
  logic [DP_EXP-1:0]  dp_exp;
  logic [DP_FRAC-1:0] dp_frac;
  logic               exp_ones;
  logic               frac_nz;

  assign sp_exp  = op_i[SP_FRAC +: SP_EXP];
  assign sp_frac = op_i[SP_FRAC-1:0];
  assign dp_exp  = op_i[DP_FRAC +: DP_EXP];
  assign dp_frac = op_i[DP_FRAC-1:0];

  always_comb begin
    if (dbl_i) begin
      exp_ones     = &dp_exp;
      frac_nz      = |dp_frac;
      info_o.neg   = op_i[DP_SIGN];
      info_o.mag   = op_i[MAG_W-1:0];
    end else begin
      exp_ones     = &sp_exp;
      frac_nz      = |sp_frac;
      info_o.neg   = op_i[SP_SIGN];
      info_o.mag   = {{(MAG_W-SP_SIGN){1'b0}}, op_i[SP_SIGN-1:0]};
    end
    info_o.nan  = exp_ones && frac_nz;
    info_o.zero = (info_o.mag == '0);
  end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
(
  input  fp_info_t a_i,
  input  fp_info_t b_i,
  output cc_t      cc_o
);

  logic mag_lt;
  logic mag_eq;

  assign mag_lt = (a_i.mag < b_i.mag);
  assign mag_eq = (a_i.mag == b_i.mag);

  always_comb begin
    if (a_i.nan || b_i.nan) begin
      cc_o = CC_UN;
    end else if (a_i.zero && b_i.zero) begin
      cc_o = CC_EQ;
    end else if (a_i.neg != b_i.neg) begin
      cc_o = a_i.neg ? CC_LT : CC_GT;
    end else if (mag_eq) begin
      cc_o = CC_EQ;
    end else if (mag_lt ^ a_i.neg) begin
      cc_o = CC_LT;
    end else begin
      cc_o = CC_GT;
    end
  end

endmodule

// File: rtl/fpcmp_status.sv
module fpcmp_status
  import fpcmp_pkg::*;
#(
  parameter int SR_W    = 32,
  parameter int CC_LSB  = 10,
  parameter int NVA_BIT = 5,
  parameter int NVM_BIT = 23
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  cc_t             cc_i,
  input  logic [SR_W-1:0] sr_i,
  output logic [SR_W-1:0] sr_o,
  output logic            trap_o,
  output logic            done_o
);

  logic [SR_W-1:0] sr_q, sr_n;
  logic            trap_q, trap_n;
  logic            done_q, done_n;
  logic            sr_en;

  assign sr_en = start_i;

  always_comb begin
    sr_n   = sr_i;
    trap_n = 1'b0;
    done_n = start_i;
    sr_n[CC_LSB +: 2] = cc_i;
    if (start_i && (cc_i == CC_UN)) begin
      if (sr_i[NVM_BIT]) begin
        trap_n = 1'b1;
      end else begin
        sr_n[NVA_BIT] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      trap_q <= trap_n;
      done_q <= done_n;
    end
  end

  assign sr_o   = sr_q;
  assign trap_o = trap_q;
  assign done_o = done_q;

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int SR_W    = 32,
  parameter int CC_LSB  = 10,
  parameter int NVA_BIT = 5,
  parameter int NVM_BIT = 23
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dbl_i,
  input  logic [OP_W-1:0] opa_i,
  input  logic [OP_W-1:0] opb_i,
  input  logic [SR_W-1:0] sr_i,
  output logic [SR_W-1:0] sr_o,
  output logic [1:0]      cc_o,
  output logic            acc_inv_o,
  output logic            trap_o,
  output logic            done_o
);

  localparam int N_OPS = 2;

  logic            rst_sync_n;
  logic [OP_W-1:0] ops [N_OPS];
  fp_info_t        info [N_OPS];
  cc_t             cc_next;

  assign ops[0] = opa_i;
  assign ops[1] = opb_i;

  fpcmp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fpcmp_classify u_cls (
      .op_i   (ops[g]),
      .dbl_i  (dbl_i),
      .info_o (info[g])
    );
  end

  fpcmp_order u_order (
    .a_i  (info[0]),
    .b_i  (info[1]),
    .cc_o (cc_next)
  );

  fpcmp_status #(
    .SR_W    (SR_W),
    .CC_LSB  (CC_LSB),
    .NVA_BIT (NVA_BIT),
    .NVM_BIT (NVM_BIT)
  ) u_status (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .cc_i    (cc_next),
    .sr_i    (sr_i),
    .sr_o    (sr_o),
    .trap_o  (trap_o),
    .done_o  (done_o)
  );

  assign cc_o      = sr_o[CC_LSB +: 2];
  assign acc_inv_o = sr_o[NVA_BIT];

endmodule

// File: rtl/fpcmp_unit_chk.sv
module fpcmp_unit_chk #(
  parameter int SR_W    = 32,
  parameter int CC_LSB  = 10,
  parameter int NVA_BIT = 5,
  parameter int NVM_BIT = 23
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            a_nan,
  input logic            b_nan,
  input logic [SR_W-1:0] sr_i,
  input logic [SR_W-1:0] sr_o,
  input logic [1:0]      cc_o,
  input logic            acc_inv_o,
  input logic            trap_o,
  input logic            done_o
);

  localparam logic [SR_W-1:0] KEEP_MASK =
    ~((({{(SR_W-2){1'b0}}, 2'b11}) << CC_LSB) | ({{(SR_W-1){1'b0}}, 1'b1} << NVA_BIT));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);

  // R9
  no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o && !trap_o);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(sr_o) && $stable(cc_o));

  // R4
  nan_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (a_nan || b_nan) |=> cc_o == 2'b11);

  // R5
  trap_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> done_o && cc_o == 2'b11);

  // R5
  trap_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (a_nan || b_nan) && sr_i[NVM_BIT] |=> trap_o);

  // R6
  accrue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && (a_nan || b_nan) && !sr_i[NVM_BIT] |=> acc_inv_o && !trap_o);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && sr_i[NVA_BIT] |=> acc_inv_o);

  // R8
  preserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (sr_o & KEEP_MASK) == ($past(sr_i) & KEEP_MASK));

endmodule

bind fpcmp_unit fpcmp_unit_chk #(
  .SR_W    (SR_W),
  .CC_LSB  (CC_LSB),
  .NVA_BIT (NVA_BIT),
  .NVM_BIT (NVM_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start_i   (start_i),
  .a_nan     (info[0].nan),
  .b_nan     (info[1].nan),
  .sr_i      (sr_i),
  .sr_o      (sr_o),
  .cc_o      (cc_o),
  .acc_inv_o (acc_inv_o),
  .trap_o    (trap_o),
  .done_o    (done_o)
);

// File: tb/fpcmp_unit_bench.sv
module fpcmp_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 19;
  localparam int VEC_W      = 131;

  // {dbl, opa, opb, expected cc}
  localparam logic [VEC_W-1:0] VEC [N_VEC] = '{
    {1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_4000_0000, 2'b01}, // R1 1<2
    {1'b0, 64'h0000_0000_4000_0000, 64'h0000_0000_3F80_0000, 2'b10}, // R1 2>1
    {1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_3F80_0000, 2'b00}, // R1 eq
    {1'b0, 64'h0000_0000_BF80_0000, 64'h0000_0000_C000_0000, 2'b10}, // R2 -1>-2
    {1'b0, 64'h0000_0000_C000_0000, 64'h0000_0000_BF80_0000, 2'b01}, // R2 -2<-1
    {1'b0, 64'h0000_0000_BF80_0000, 64'h0000_0000_3F80_0000, 2'b01}, // R2 mixed
    {1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_8000_0000, 2'b00}, // R3 +0 -0
    {1'b0, 64'h0000_0000_7FC0_0000, 64'h0000_0000_3F80_0000, 2'b11}, // R4 qnan
    {1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_7F80_0001, 2'b11}, // R4 snan
    {1'b0, 64'h0000_0000_7F80_0000, 64'h0000_0000_7F7F_FFFF, 2'b10}, // R4 inf
    {1'b0, 64'h0000_0000_7F80_0000, 64'h0000_0000_7F80_0000, 2'b00}, // R4 inf eq
    {1'b0, 64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_4000_0000, 2'b01}, // R7 upper ignored
    {1'b1, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 2'b01}, // R1 dbl
    {1'b1, 64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000, 2'b10}, // R2 dbl
    {1'b1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, 2'b00}, // R3 dbl
    {1'b1, 64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, 2'b11}, // R4 dbl
    {1'b1, 64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0001, 2'b11}, // R4 dbl snan
    {1'b1, 64'h7FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 2'b10}, // R4 dbl inf
    {1'b1, 64'h3FF0_0000_0000_0000, 64'h0000_0000_7FC0_0000, 2'b10}  // R7 low word
  };

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        dbl_i;
  logic [63:0] opa_i;
  logic [63:0] opb_i;
  logic [31:0] sr_i;
  logic [31:0] sr_o;
  logic [1:0]  cc_o;
  logic        acc_inv_o;
  logic        trap_o;
  logic        done_o;

  int checks;
  int errors;
  bit finished;

  fpcmp_unit u_fpcmp_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .dbl_i     (dbl_i),
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .sr_i      (sr_i),
    .sr_o      (sr_o),
    .cc_o      (cc_o),
    .acc_inv_o (acc_inv_o),
    .trap_o    (trap_o),
    .done_o    (done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_sr(input logic [31:0] sr, input logic [1:0] cc);
    logic [31:0] r;
    r = sr;
    r[11:10] = cc;
    if (cc == 2'b11 && !sr[23]) r[5] = 1'b1;
    return r;
  endfunction

  task automatic run(input logic dbl, input logic [63:0] a, input logic [63:0] b,
                     input logic [31:0] sr);
    @(negedge clk);
    dbl_i = dbl; opa_i = a; opb_i = b; sr_i = sr; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; start_i = 1'b0; dbl_i = 1'b0;
    opa_i = '0; opb_i = '0; sr_i = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 sr_o", 64'(sr_o), 64'h0);
    chk("R10 done/trap/acc/cc", 64'({done_o, trap_o, acc_inv_o, cc_o}), 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < N_VEC; i++) begin
      for (int k = 0; k < 2; k++) begin
        logic [VEC_W-1:0] v;
        logic [31:0] sr;
        logic [1:0]  ec;
        logic [31:0] esr;
        string tag;
        v  = VEC[i];
        ec = v[1:0];
        sr = 32'h3C5A_96E1 ^ (32'(i) * 32'h0101_0101);
        sr[5] = 1'b0;
        sr[23] = k[0];
        sr[11:10] = ~ec;
        esr = exp_sr(sr, ec);
        tag = (ec == 2'b11) ? "R4" : "R1";
        run(v[130], v[129:66], v[65:2], sr);
        chk({tag, " cc"}, 64'(cc_o), 64'(ec));
        chk("R8 sr_o", 64'(sr_o), 64'(esr));
        chk("R8 done", 64'(done_o), 64'h1);
        chk("R5 trap", 64'(trap_o), 64'((ec == 2'b11) && k == 1));
        chk("R6 acc", 64'(acc_inv_o), 64'((ec == 2'b11) && k == 0));
      end
    end

    // R9 hold: change inputs without start
    run(1'b0, 64'h0000_0000_C000_0000, 64'h0000_0000_3F80_0000, 32'h0000_0000);
    dbl_i = 1'b1; opa_i = 64'h7FF8_0000_0000_0000; sr_i = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R9 hold cc", 64'(cc_o), 64'h1);
    chk("R9 hold sr", 64'(sr_o), 64'h0000_0400);
    chk("R9 done low", 64'({done_o, trap_o}), 64'h0);

    // R6 sticky accrued bit on ordered compare
    run(1'b0, 64'h0000_0000_4000_0000, 64'h0000_0000_3F80_0000, 32'h0000_0020);
    chk("R6 sticky", 64'(acc_inv_o), 64'h1);
    chk("R6 sticky sr", 64'(sr_o), 64'h0000_0820);

    // R5 trap leaves accrued set bit as given
    run(1'b1, 64'h7FF8_0000_0000_0001, 64'h0, 32'h0080_0020);
    chk("R5 trap with acc", 64'({trap_o, acc_inv_o}), 64'h3);

    // R3 -0 vs -0 single
    run(1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 32'h0);
    chk("R3 -0 -0", 64'(cc_o), 64'h0);

    // R2 negative zero below positive
    run(1'b1, 64'h8000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 32'h0);
    chk("R2 -0 < 1", 64'(cc_o), 64'h1);

    // R10 reset in mid-run clears outputs
    rst_n = 1'b0;
    #1;
    chk("R10 async", 64'({sr_o, done_o, trap_o}), 64'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule